// File: doc/BRIEF.md
# Memory Read Latency Auto-Calibrator

This block sits beside an address generator that fetches operands from an external memory whose read latency is fixed but not known at design time. It learns that latency at run time. It counts clock cycles from the first asserted address strobe to the first asserted return strobe. Twiddle and data fetches are taken to share this one value, and it stays constant for the rest of the transform.

Each address is issued together with a metadata word, such as a sample index or a pass tag. The block sends every metadata word through a 16-entry shift register. It then reads that register at the learned depth, so each returning data word comes with the metadata of the address that fetched it. This includes the very first returned word, which is aligned in the cycle the latency is learned.

A start pulse clears the learned value and arms a new measurement. If nothing returns within the counting window, an error flag is raised instead of a lock.

Top module: `rdlat_cal`

## Requirements
- R1: After reset, `locked_o`, `lat_err_o`, `meta_vld_o` are 0 and `lat_o` is 0; the block is idle until a start pulse.
- R2: After a start pulse, the first cycle with `addr_vld_i` high begins the measurement; `data_vld_i` seen before that first address is ignored.
- R3: If `data_vld_i` is first high L cycles after the first address (1 <= L <= 15), then from the next cycle `locked_o` is 1 and `lat_o` equals L.
- R4: If `data_vld_i` stays low in all of the 15 cycles that follow the first address, `lat_err_o` rises in the cycle after the 15th. It stays high until the next start or reset, and `locked_o` stays 0.
- R5: In any cycle where `data_vld_i` is high and the block is locked, or is locking in that very cycle, `meta_vld_o` is 1. In that cycle `meta_o` equals the `meta_i` presented exactly L cycles earlier. In all other cycles `meta_vld_o` is 0.
- R6: Once locked, `lat_o` and `locked_o` do not change until a start pulse, whatever the strobes do.
- R7: A start pulse makes `locked_o`, `lat_err_o` and `lat_o` all 0 in the next cycle and arms a new measurement.
- R8: While idle (after reset, before any start), address and data strobes have no effect: no lock, no error, `meta_vld_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse: clear and re-arm measurement |
| addr_vld_i | input | 1 | Address issued to memory this cycle |
| meta_i | input | META_W | Metadata travelling with the address |
| data_vld_i | input | 1 | Memory returned data this cycle |
| meta_o | output | META_W | Metadata aligned to the returning data |
| meta_vld_o | output | 1 | `meta_o` is valid this cycle |
| lat_o | output | LAT_W | Learned latency in cycles |
| locked_o | output | 1 | Latency learned and in use |
| lat_err_o | output | 1 | No data returned within the window |

## Verification
Every cycle, the assertions check the following. Lock and error are never raised together. A held lock keeps a constant, non-zero latency. An error stays sticky. A start clears all state in the next cycle. The aligned-valid output never fires without a returning data strobe. Only the bench scenarios can show the rest: that the counted value matches the true distance between strobes across several latencies, including the 15-cycle limit and the 16-cycle miss, and that each returned word gets exactly the metadata of its own address. The same holds for the rule that strobes before arming or before the first address are disregarded.

// File: rtl/rdlat_pkg.sv
`timescale 1ns/1ps
package rdlat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_COUNT = 3'd2,
        ST_LOCK  = 3'd3,
        ST_ERR   = 3'd4
    } cal_state_t;

    // Largest value a counter of the given width can reach.
    function automatic int unsigned cnt_top(input int unsigned width);
        return (1 << width) - 1;
    endfunction

endpackage

// File: rtl/rdlat_meas.sv
`timescale 1ns/1ps
module rdlat_meas
    import rdlat_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             addr_vld_i,
    input  logic             data_vld_i,
    output logic [LAT_W-1:0] lat_o,
    output logic             locked_o,
    output logic             err_o,
    output logic [LAT_W-1:0] tap_sel_o,
    output logic             tap_en_o
);
    localparam logic [LAT_W-1:0] CNT_MAX = LAT_W'(cnt_top(LAT_W));

    cal_state_t       st_q;
    logic [LAT_W-1:0] cnt_q;
    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            lat_q <= '0;
        end else if (start_i) begin
            st_q  <= ST_ARM;
            cnt_q <= '0;
            lat_q <= '0;
        end else begin
            case (st_q)
                ST_ARM: begin
                    if (addr_vld_i) begin
                        cnt_q <= LAT_W'(1);
                        st_q  <= ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (data_vld_i) begin
                        lat_q <= cnt_q;
                        st_q  <= ST_LOCK;
                    end else if (cnt_q == CNT_MAX) begin
                        st_q  <= ST_ERR;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tap_en_o  = data_vld_i && ((st_q == ST_LOCK) || (st_q == ST_COUNT));
        tap_sel_o = (st_q == ST_COUNT) ? cnt_q : lat_q;
    end

    assign lat_o    = lat_q;
    assign locked_o = (st_q == ST_LOCK);
    assign err_o    = (st_q == ST_ERR);

endmodule

// File: rtl/rdlat_dly.sv
`timescale 1ns/1ps
module rdlat_dly #(
    parameter int W     = 16,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     din_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             en_i,
    output logic [W-1:0]     dout_o
);
    localparam int DEPTH = 1 << SEL_W;

    logic [W-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= din_i;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= '0;
            else     stage_q[g] <= stage_q[g-1];
        end
    end

    // stage k holds the word presented k+1 cycles ago.
    logic [SEL_W-1:0] idx;
    always_comb begin
        idx    = sel_i - 1'b1;
        dout_o = en_i ? stage_q[idx] : '0;
    end

endmodule

// File: rtl/rdlat_cal.sv
`timescale 1ns/1ps
module rdlat_cal #(
    parameter int META_W = 16,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              addr_vld_i,
    input  logic [META_W-1:0] meta_i,
    input  logic              data_vld_i,
    output logic [META_W-1:0] meta_o,
    output logic              meta_vld_o,
    output logic [LAT_W-1:0]  lat_o,
    output logic              locked_o,
    output logic              lat_err_o
);
    logic [LAT_W-1:0] tap_sel;
    logic             tap_en;

    rdlat_meas #(.LAT_W(LAT_W)) u_meas (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .addr_vld_i (addr_vld_i),
        .data_vld_i (data_vld_i),
        .lat_o      (lat_o),
        .locked_o   (locked_o),
        .err_o      (lat_err_o),
        .tap_sel_o  (tap_sel),
        .tap_en_o   (tap_en)
    );

    rdlat_dly #(.W(META_W), .SEL_W(LAT_W)) u_dly (
        .clk    (clk),
        .rst    (rst),
        .din_i  (meta_i),
        .sel_i  (tap_sel),
        .en_i   (tap_en),
        .dout_o (meta_o)
    );

    assign meta_vld_o = tap_en;

endmodule

// File: rtl/rdlat_cal_chk.sv
`timescale 1ns/1ps
module rdlat_cal_chk #(
    parameter int META_W = 16,
    parameter int LAT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              data_vld_i,
    input logic              meta_vld_o,
    input logic [LAT_W-1:0]  lat_o,
    input logic              locked_o,
    input logic              lat_err_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!locked_o && !lat_err_o && !meta_vld_o && lat_o == '0));

    assert_lat_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> (lat_o != '0));

    assert_lock_err_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(locked_o && lat_err_o));

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (lat_err_o && !start_i) |=> lat_err_o);

    assert_vld_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
        meta_vld_o |-> data_vld_i);

    assert_lock_held_R6: assert property (@(posedge clk) disable iff (rst)
        (locked_o && !start_i) |=> (locked_o && lat_o == $past(lat_o)));

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!locked_o && !lat_err_o && lat_o == '0));

endmodule

bind rdlat_cal rdlat_cal_chk #(.META_W(META_W), .LAT_W(LAT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .data_vld_i (data_vld_i),
    .meta_vld_o (meta_vld_o),
    .lat_o      (lat_o),
    .locked_o   (locked_o),
    .lat_err_o  (lat_err_o)
);

// File: tb/rdlat_cal_tb.sv
`timescale 1ns/1ps
module rdlat_cal_tb;
    localparam int META_W = 16;
    localparam int LAT_W  = 4;
    localparam int NV     = 5;
    localparam int LAT_TAB  [NV] = '{1, 2, 5, 7, 15};
    localparam int BASE_TAB [NV] = '{16'h0100, 16'h0200, 16'h0A00, 16'h3000, 16'h7F00};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              addr_vld_i = 1'b0;
    logic [META_W-1:0] meta_i = '0;
    logic              data_vld_i = 1'b0;
    logic [META_W-1:0] meta_o;
    logic              meta_vld_o;
    logic [LAT_W-1:0]  lat_o;
    logic              locked_o;
    logic              lat_err_o;

    int nchk  = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    rdlat_cal #(.META_W(META_W), .LAT_W(LAT_W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .addr_vld_i(addr_vld_i),
        .meta_i(meta_i), .data_vld_i(data_vld_i), .meta_o(meta_o),
        .meta_vld_o(meta_vld_o), .lat_o(lat_o), .locked_o(locked_o),
        .lat_err_o(lat_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1; addr_vld_i = 1'b0; data_vld_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Address burst of 20 from offset 0, data burst of 20 from offset lat.
    task automatic run_stream(input int lat, input int base);
        for (int c = 0; c < lat + 21; c++) begin
            addr_vld_i = (c < 20);
            meta_i     = META_W'(base + c);
            data_vld_i = (c >= lat) && (c < lat + 20);
            #1;
            if (data_vld_i) begin
                chk(meta_vld_o == 1'b1, "R5 meta_vld", int'(meta_vld_o), 1);
                chk(meta_o == META_W'(base + c - lat), "R5 meta align",
                    int'(meta_o), base + c - lat);
            end else begin
                chk(meta_vld_o == 1'b0, "R5 meta_vld idle", int'(meta_vld_o), 0);
            end
            @(negedge clk);
        end
        addr_vld_i = 1'b0; data_vld_i = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!locked_o && !lat_err_o && !meta_vld_o && lat_o == 0, "R1 reset",
            {locked_o, lat_err_o, meta_vld_o, lat_o}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R8 idle: strobes ignored before any start
        for (int c = 0; c < 20; c++) begin
            addr_vld_i = 1'b1; data_vld_i = 1'b1; meta_i = META_W'(c);
            #1;
            if (c == 10) chk(meta_vld_o == 1'b0, "R8 idle meta_vld", int'(meta_vld_o), 0);
            @(negedge clk);
        end
        addr_vld_i = 1'b0; data_vld_i = 1'b0;
        chk(!locked_o && !lat_err_o, "R8 idle no lock", {locked_o, lat_err_o}, 0);

        // R3/R5 table of latencies
        for (int v = 0; v < NV; v++) begin
            pulse_start();
            run_stream(LAT_TAB[v], BASE_TAB[v]);
            chk(locked_o == 1'b1, "R3 locked", int'(locked_o), 1);
            chk(int'(lat_o) == LAT_TAB[v], "R3 latency", int'(lat_o), LAT_TAB[v]);
        end

        // R6: further strobes after lock leave latency untouched
        for (int c = 0; c < 6; c++) begin
            addr_vld_i = (c < 3); data_vld_i = (c >= 2);
            @(negedge clk);
        end
        addr_vld_i = 1'b0; data_vld_i = 1'b0;
        chk(locked_o && lat_o == 15, "R6 lock held", int'(lat_o), 15);

        // R7: start clears, next cycle
        pulse_start();
        chk(!locked_o && !lat_err_o && lat_o == 0, "R7 start clears",
            {locked_o, lat_err_o, lat_o}, 0);

        // R2: data before first address ignored
        for (int c = 0; c < 3; c++) begin
            data_vld_i = 1'b1; #1;
            chk(meta_vld_o == 1'b0, "R2 early data", int'(meta_vld_o), 0);
            @(negedge clk);
        end
        data_vld_i = 1'b0;
        @(negedge clk);
        chk(!locked_o, "R2 no early lock", int'(locked_o), 0);
        run_stream(3, 16'h5500);
        chk(locked_o && lat_o == 3, "R2 latency after early data", int'(lat_o), 3);

        // R4: data at offset 16 is too late
        pulse_start();
        for (int c = 0; c < 20; c++) begin
            addr_vld_i = (c < 20); meta_i = META_W'(c);
            data_vld_i = (c == 16);
            #1;
            if (c == 15) chk(lat_err_o == 1'b0, "R4 no error at 15", int'(lat_err_o), 0);
            if (c == 16) begin
                chk(lat_err_o == 1'b1, "R4 error at 16", int'(lat_err_o), 1);
                chk(meta_vld_o == 1'b0, "R4 late data not valid", int'(meta_vld_o), 0);
            end
            @(negedge clk);
        end
        addr_vld_i = 1'b0; data_vld_i = 1'b0;
        chk(lat_err_o && !locked_o, "R4 sticky no lock", {lat_err_o, locked_o}, 2);

        // R7: start clears the error, re-measure
        pulse_start();
        chk(!lat_err_o, "R7 error cleared", int'(lat_err_o), 0);
        run_stream(2, 16'h6600);
        chk(locked_o && lat_o == 2, "R7 re-measure", int'(lat_o), 2);

        // R1: reset while locked
        rst = 1'b1;
        @(negedge clk);
        chk(!locked_o && lat_o == 0, "R1 reset while locked", int'(lat_o), 0);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule